// File: doc/BRIEF.md
# Keyed-Command Flash Bank Programmer

This block erases or programs one bank of a byte-wide parallel flash whose commands are only accepted after a two-write key sequence. A bank holds `2**ADDR_W` bytes (8 KiB by default), and `bank` selects which bank is used. On `start` the block takes an operation code. For an erase it issues one sector-erase command to the bank. For a program it issues one single-byte program command per byte, in ascending offset order, and takes each data byte from an image buffer through a combinational read port. After every write the block leaves a programmable idle gap before the next write.

The block does not read a status register. It finds the end of each command by reading the bank base twice on back-to-back cycles. While the device is busy the two reads differ, and the command is finished once they match. If they have not matched after a set number of tries, the block abandons the operation. In every case it then writes the reset command to the bank base, waits one gap, and reads the bank back. An erased bank must read 0xFF everywhere, and a programmed bank must match the image. The block then pulses `done`, and `error` reports whether the operation failed.

Top module: `flash_bank_prog`

## Requirements
- R1: With op = 2'b01 (erase), the block writes exactly six command cycles, as (bank offset, data): (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55), (0x000,0x30). It then polls, and an error-free erase leaves every byte of the bank at 0xFF.
- R2: With op = 2'b10 (program), the block handles each offset from 0 up to the last offset in order. For each offset it writes (0x555,0xAA), (0x2AA,0x55), (0x555,0xA0), and then the image byte at that offset, and it polls between bytes.
- R3: After every write strobe, at least GAP_CYC cycles pass with no write strobe.
- R4: Polling reads bank offset 0 on two consecutive cycles, with no write between them. Read data is taken on the cycle after the read strobe. Polling repeats until the two values are equal, and only then does the block move on.
- R5: After TOGGLE_MAX unequal read pairs on one command, the block sends no further command cycles. It continues with the reset write and finishes with error = 1.
- R6: After the command phase, and before any verify read, the block writes 0xF0 to bank offset 0 exactly once and then waits GAP_CYC cycles.
- R7: An erase is verified by reading every offset of the bank. Any byte other than 0xFF ends the operation with error = 1.
- R8: A program is verified against the image buffer at every offset. Any mismatch, such as a byte that was not erased beforehand, ends the operation with error = 1.
- R9: An op code of 2'b00 or 2'b11 pulses done with error = 1 on the next cycle and causes no read or write strobe.
- R10: The upper BANK_W bits of fl_addr equal the bank captured at start for every strobe of an operation.
- R11: done is a single-cycle pulse. error keeps its value until the next accepted start, which clears it. A start raised while busy is ignored.
- R12: After reset the block is idle, with busy, done, error, fl_we and fl_re all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| op | input | 2 | 01 erase, 10 program, others illegal |
| bank | input | BANK_W | Bank to operate on |
| img_addr | output | ADDR_W | Image buffer read offset |
| img_data | input | 8 | Image byte at img_addr (combinational) |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_addr | output | ADDR_W+BANK_W | Flash byte address, bank in the top bits |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data, valid the cycle after fl_re |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Outcome of the last operation |

## Verification
The flash model in the bench decodes every write against the key sequences. It answers polls with alternating status values while busy, and it clears bits on program, as a real flash does. The erase runs on two banks check that bank selection works and that each erase needs several unequal poll pairs. Two program runs with different images tell a correct program apart from one that skips the erase: the first writes over an erased bank and must verify, while the second writes over stale data and must fail the verify. A device stuck busy, a byte that will not erase, and illegal op codes each separate the timeout, erase-verify and decode paths from the normal flow.

// File: rtl/flash_bank_prog.sv
module flash_bank_prog #(
  parameter int ADDR_W     = 13,
  parameter int BANK_W     = 1,
  parameter int GAP_CYC    = 250,
  parameter int TOGGLE_MAX = 1000000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [1:0]               op,
  input  logic [BANK_W-1:0]        bank,
  output logic [ADDR_W-1:0]        img_addr,
  input  logic [7:0]               img_data,
  output logic                     fl_we,
  output logic                     fl_re,
  output logic [ADDR_W+BANK_W-1:0] fl_addr,
  output logic [7:0]               fl_wdata,
  input  logic [7:0]               fl_rdata,
  output logic                     busy,
  output logic                     done,
  output logic                     error
);

  localparam int GW = $clog2(GAP_CYC + 1);
  localparam int TW = $clog2(TOGGLE_MAX + 1);
  localparam logic [1:0] OP_ERASE = 2'b01;
  localparam logic [1:0] OP_PROG  = 2'b10;
  localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] KEY_B = ADDR_W'(12'h2AA);
  localparam logic [ADDR_W-1:0] LAST  = '1;
  localparam logic [GW-1:0] GAP_END = GW'(GAP_CYC - 1);
  localparam logic [TW-1:0] TRY_END = TW'(TOGGLE_MAX - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_WR, S_GAP, S_P1, S_P2, S_P3, S_RST, S_RGAP, S_VRD, S_VCK
  } st_t;

  st_t               st;
  logic              is_prog, timed_out;
  logic [BANK_W-1:0] bank_r;
  logic [2:0]        step;
  logic [ADDR_W-1:0] idx, cmd_off, loc;
  logic [GW-1:0]     gap_cnt;
  logic [TW-1:0]     tries;
  logic [7:0]        first_rd, cmd_dat, exp_byte;
  logic              op_ok, last_step;

  assign op_ok     = (op == OP_ERASE) || (op == OP_PROG);
  assign last_step = is_prog ? (step == 3'd3) : (step == 3'd5);
  assign exp_byte  = is_prog ? img_data : 8'hFF;

  always_comb begin
    cmd_off = KEY_A;
    cmd_dat = 8'hAA;
    case (step)
      3'd0: ;
      3'd1: begin cmd_off = KEY_B; cmd_dat = 8'h55; end
      3'd2: cmd_dat = is_prog ? 8'hA0 : 8'h80;
      3'd3: if (is_prog) begin cmd_off = idx; cmd_dat = img_data; end
      3'd4: begin cmd_off = KEY_B; cmd_dat = 8'h55; end
      default: begin cmd_off = '0; cmd_dat = 8'h30; end
    endcase
  end

  always_comb begin
    case (st)
      S_WR:    loc = cmd_off;
      S_VRD:   loc = idx;
      default: loc = '0;
    endcase
  end

  assign fl_we    = (st == S_WR) || (st == S_RST);
  assign fl_re    = (st == S_P1) || (st == S_P2) || (st == S_VRD);
  assign fl_addr  = {bank_r, loc};
  assign fl_wdata = (st == S_WR) ? cmd_dat : ((st == S_RST) ? 8'hF0 : 8'h00);
  assign img_addr = idx;
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; is_prog <= 1'b0; timed_out <= 1'b0; bank_r <= '0;
      step <= '0; idx <= '0; gap_cnt <= '0; tries <= '0; first_rd <= '0;
      done <= 1'b0; error <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (!op_ok) begin
            done  <= 1'b1;
            error <= 1'b1;
          end else begin
            error     <= 1'b0;
            is_prog   <= (op == OP_PROG);
            bank_r    <= bank;
            timed_out <= 1'b0;
            step      <= '0;
            idx       <= '0;
            st        <= S_WR;
          end
        end
        S_WR: begin
          gap_cnt <= '0;
          st      <= S_GAP;
        end
        S_GAP: begin
          gap_cnt <= gap_cnt + 1'b1;
          if (gap_cnt == GAP_END) begin
            if (last_step) begin
              tries <= '0;
              st    <= S_P1;
            end else begin
              step <= step + 1'b1;
              st   <= S_WR;
            end
          end
        end
        S_P1: st <= S_P2;
        S_P2: begin
          first_rd <= fl_rdata;
          st       <= S_P3;
        end
        S_P3: begin
          if (first_rd == fl_rdata) begin
            if (is_prog && idx != LAST) begin
              idx  <= idx + 1'b1;
              step <= '0;
              st   <= S_WR;
            end else begin
              st <= S_RST;
            end
          end else if (tries == TRY_END) begin
            timed_out <= 1'b1;
            st        <= S_RST;
          end else begin
            tries <= tries + 1'b1;
            st    <= S_P1;
          end
        end
        S_RST: begin
          gap_cnt <= '0;
          st      <= S_RGAP;
        end
        S_RGAP: begin
          gap_cnt <= gap_cnt + 1'b1;
          if (gap_cnt == GAP_END) begin
            idx <= '0;
            st  <= S_VRD;
          end
        end
        S_VRD: st <= S_VCK;
        S_VCK: begin
          if (fl_rdata != exp_byte || idx == LAST) begin
            done  <= 1'b1;
            error <= timed_out || (fl_rdata != exp_byte);
            st    <= S_IDLE;
          end else begin
            idx <= idx + 1'b1;
            st  <= S_VRD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  gap_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |=> !fl_we);

  // R4
  toggle_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_re && st == S_P1) |=> (fl_re && !fl_we && fl_addr == $past(fl_addr)));

  // R9
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !op_ok) |=> (done && error && !fl_we && !fl_re));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(error));

  // R11
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op_ok) |=> (busy && !error));

endmodule

// File: tb/flash_bank_prog_test.sv
`timescale 1ns/1ps
module flash_bank_prog_test;
  localparam int AW   = 11;
  localparam int GAP  = 1;
  localparam int TMAX = 20;
  localparam int NB   = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] op = 2'b00;
  logic bank = 1'b0;
  logic [AW-1:0] img_addr;
  logic [7:0] img_data;
  logic fl_we, fl_re, busy, done, error;
  logic [AW:0] fl_addr;
  logic [7:0] fl_wdata, fl_rdata;

  always #2 clk = ~clk;

  flash_bank_prog #(.ADDR_W(AW), .BANK_W(1), .GAP_CYC(GAP), .TOGGLE_MAX(TMAX)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bank(bank),
    .img_addr(img_addr), .img_data(img_data), .fl_we(fl_we), .fl_re(fl_re),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
    .busy(busy), .done(done), .error(error));

  logic [7:0] img [0:NB-1];
  assign img_data = img[img_addr];

  // flash model
  logic [7:0] mem [0:2*NB-1];
  logic hang_arm = 1'b0, weak_en = 1'b0, cur_bank = 1'b0;
  logic hang_now, tog, post_f0;
  int cst, busy_cnt, since, prog_next;
  int n_proto, n_gap, n_bank, n_order, n_erase, n_prog, n_f0, n_busy_rd, n_post, n_wr, n_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2*NB; i++) mem[i] <= 8'h00;
      hang_now <= 0; tog <= 0; post_f0 <= 0; fl_rdata <= 8'h00;
      cst <= 0; busy_cnt <= 0; since <= 1000; prog_next <= 0;
      n_proto <= 0; n_gap <= 0; n_bank <= 0; n_order <= 0; n_erase <= 0; n_prog <= 0;
      n_f0 <= 0; n_busy_rd <= 0; n_post <= 0; n_wr <= 0; n_rd <= 0;
    end else begin
      if (fl_we) begin
        n_wr <= n_wr + 1;
        since <= 1;
        if (since < GAP + 1) n_gap <= n_gap + 1;
        if (fl_addr[AW] != cur_bank) n_bank <= n_bank + 1;
        if (cst == 0 && fl_addr[AW-1:0] == 0 && fl_wdata == 8'hF0) begin
          n_f0 <= n_f0 + 1; busy_cnt <= 0; hang_now <= 0; prog_next <= 0; post_f0 <= 1;
        end else begin
          case (cst)
            0: if (fl_addr[AW-1:0] == 11'h555 && fl_wdata == 8'hAA) begin cst <= 1; post_f0 <= 0; end
               else n_proto <= n_proto + 1;
            1: if (fl_addr[AW-1:0] == 11'h2AA && fl_wdata == 8'h55) cst <= 2;
               else begin n_proto <= n_proto + 1; cst <= 0; end
            2: if (fl_addr[AW-1:0] == 11'h555 && fl_wdata == 8'h80) cst <= 3;
               else if (fl_addr[AW-1:0] == 11'h555 && fl_wdata == 8'hA0) cst <= 6;
               else begin n_proto <= n_proto + 1; cst <= 0; end
            3: if (fl_addr[AW-1:0] == 11'h555 && fl_wdata == 8'hAA) cst <= 4;
               else begin n_proto <= n_proto + 1; cst <= 0; end
            4: if (fl_addr[AW-1:0] == 11'h2AA && fl_wdata == 8'h55) cst <= 5;
               else begin n_proto <= n_proto + 1; cst <= 0; end
            5: begin
              cst <= 0;
              if (fl_addr[AW-1:0] == 0 && fl_wdata == 8'h30) begin
                for (int i = 0; i < NB; i++) mem[{fl_addr[AW], AW'(i)}] <= 8'hFF;
                if (weak_en) mem[{fl_addr[AW], 11'h123}] <= 8'h00;
                n_erase <= n_erase + 1; busy_cnt <= 4; hang_now <= hang_arm;
              end else n_proto <= n_proto + 1;
            end
            default: begin
              cst <= 0;
              mem[fl_addr] <= mem[fl_addr] & fl_wdata;
              if (int'(fl_addr[AW-1:0]) != prog_next) n_order <= n_order + 1;
              prog_next <= int'(fl_addr[AW-1:0]) + 1;
              n_prog <= n_prog + 1; busy_cnt <= 2; hang_now <= hang_arm;
            end
          endcase
        end
      end else if (since < 1000) since <= since + 1;
      if (fl_re) begin
        n_rd <= n_rd + 1;
        if (fl_addr[AW] != cur_bank) n_bank <= n_bank + 1;
        if (post_f0) n_post <= n_post + 1;
        if ((busy_cnt > 0 || hang_now) && fl_addr[AW-1:0] == 0) begin
          fl_rdata <= tog ? 8'h44 : 8'h04;
          tog <= ~tog;
          n_busy_rd <= n_busy_rd + 1;
          if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
        end else fl_rdata <= mem[fl_addr];
      end
    end
  end

  int errors = 0, checks = 0;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic fill_img(input logic [7:0] seed);
    for (int i = 0; i < NB; i++) img[i] = 8'(i * seed) ^ 8'(i >> 3) ^ seed;
  endtask

  int b_proto, b_gap, b_bank, b_order, b_erase, b_prog, b_f0, b_busy, b_post, b_wr, b_rd;

  task automatic snap();
    b_proto = n_proto; b_gap = n_gap; b_bank = n_bank; b_order = n_order;
    b_erase = n_erase; b_prog = n_prog; b_f0 = n_f0; b_busy = n_busy_rd;
    b_post = n_post; b_wr = n_wr; b_rd = n_rd;
  endtask

  task automatic run(input logic [1:0] o, input logic b);
    snap();
    cur_bank = b;
    @(negedge clk); start = 1'b1; op = o; bank = b;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  localparam logic [11:0] VEC [5] = '{
    {2'b01, 1'b1, 8'h00, 1'b0},
    {2'b01, 1'b0, 8'h00, 1'b0},
    {2'b10, 1'b0, 8'h35, 1'b0},
    {2'b10, 1'b0, 8'h5B, 1'b1},
    {2'b01, 1'b0, 8'h00, 1'b0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    fill_img(8'h11);
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!busy && !done && !error && !fl_we && !fl_re, "R12 idle after reset",
          {busy, done, error, fl_we, fl_re}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 5; v++) begin
      logic [1:0] vo; logic vb; logic [7:0] vs; logic ve; bit okm;
      {vo, vb, vs, ve} = VEC[v];
      if (vo == 2'b10) fill_img(vs);
      run(vo, vb);
      if (vo == 2'b01) begin
        check(error == ve, "R7 erase result", error, ve);
        check(n_erase - b_erase == 1 && n_prog == b_prog, "R1 one erase command", n_erase - b_erase, 1);
        check(n_busy_rd - b_busy == 4, "R4 polled through busy", n_busy_rd - b_busy, 4);
        okm = 1;
        for (int i = 0; i < NB; i++) if (mem[{vb, AW'(i)}] != 8'hFF) okm = 0;
        check(okm, "R1 bank erased", okm, 1);
        check(n_post - b_post == NB, "R7 every byte verified", n_post - b_post, NB);
      end else begin
        check(error == ve, "R8 program result", error, ve);
        check(n_prog - b_prog == NB && n_erase == b_erase, "R2 one program command per byte",
              n_prog - b_prog, NB);
        check(n_order == b_order, "R2 ascending offsets", n_order - b_order, 0);
        check(n_busy_rd - b_busy == 2*NB, "R4 polled through busy", n_busy_rd - b_busy, 2*NB);
        if (!ve) begin
          okm = 1;
          for (int i = 0; i < NB; i++) if (mem[{vb, AW'(i)}] != img[i]) okm = 0;
          check(okm, "R8 bank holds image", okm, 1);
        end
      end
      check(n_proto == b_proto, "R1 R2 key sequence", n_proto - b_proto, 0);
      check(n_gap == b_gap, "R3 write gap", n_gap - b_gap, 0);
      check(n_bank == b_bank, "R10 bank bits", n_bank - b_bank, 0);
      check(n_f0 - b_f0 == 1, "R6 single reset write", n_f0 - b_f0, 1);
      @(negedge clk);
      check(!done, "R11 done is one cycle", done, 0);
    end

    // R9 illegal codes
    for (int k = 0; k < 2; k++) begin
      run(k == 0 ? 2'b00 : 2'b11, 1'b0);
      check(done && error, "R9 illegal op flagged", {done, error}, 2'b11);
      check(n_wr == b_wr && n_rd == b_rd, "R9 no bus activity", n_wr - b_wr + n_rd - b_rd, 0);
    end

    // R11 error held, then cleared on accepted start
    repeat (3) @(negedge clk);
    check(error, "R11 error holds while idle", error, 1);
    snap();
    cur_bank = 1'b0;
    @(negedge clk); start = 1'b1; op = 2'b01; bank = 1'b0;
    @(negedge clk); start = 1'b0;
    check(busy && !error, "R11 start clears error", {busy, error}, 2'b10);
    repeat (4) @(negedge clk);
    start = 1'b1; op = 2'b10;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    check(n_prog == b_prog && n_erase - b_erase == 1, "R11 start while busy ignored",
          n_prog - b_prog, 0);

    // R5 timeouts
    hang_arm = 1'b1;
    run(2'b01, 1'b1);
    check(error, "R5 erase timeout flagged", error, 1);
    check(n_f0 - b_f0 == 1 && n_erase - b_erase == 1, "R5 erase timeout then reset", n_f0 - b_f0, 1);
    fill_img(8'h27);
    run(2'b10, 1'b1);
    check(error, "R5 program timeout flagged", error, 1);
    check(n_prog - b_prog == 1, "R5 no bytes after timeout", n_prog - b_prog, 1);
    check(n_f0 - b_f0 == 1, "R6 reset after timeout", n_f0 - b_f0, 1);
    hang_arm = 1'b0;

    // R7 byte that will not erase
    weak_en = 1'b1;
    run(2'b01, 1'b0);
    check(error, "R7 erase verify failure", error, 1);
    weak_en = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule